// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Parity Check

This block receives asynchronous serial frames on one input line. A two-flop synchronizer brings the line into the clock domain. A falling edge on the line starts a frame. The receiver then counts a 16x oversampling tick and samples each bit near its centre.

Word length, parity mode and stop-bit count come from static configuration inputs, using the same settings as the matching transmitter. Once the last stop bit has been sampled, the block presents the reassembled word together with a one-cycle valid pulse. A parity-error flag and a framing-error flag are valid in that same cycle. There is no buffering: a consumer that needs words held must capture them on the valid pulse.

Top module: `ser_rx`

## Requirements
- R1: The line passes through two synchronizing flops before edge detection. A falling edge in idle starts a frame. The start bit is accepted only if the line is still low 8 ticks after the edge. Otherwise the receiver goes back to idle and produces no word.
- R2: Data bits arrive least-significant first and land in `rx_word` in that order. Bit 0 of the word is the first bit after the start bit.
- R3: `cfg_len` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The upper bits of `rx_word` that are not used read as 0.
- R4: With `cfg_par` = 1 (even), `par_err` is set when the number of ones in the data bits plus the parity bit is odd.
- R5: With `cfg_par` = 2 (odd), `par_err` is set when the number of ones in the data bits plus the parity bit is even.
- R6: With `cfg_par` = 3 (mark), `par_err` is set when the parity bit is not 1. With `cfg_par` = 4 (space), `par_err` is set when the parity bit is not 0.
- R7: With `cfg_par` = 0, or with any code from 5 to 7, the frame has no parity slot and `par_err` stays 0.
- R8: `cfg_stop2` = 1 expects two stop bits and 0 expects one. If any stop bit is sampled low, `frm_err` is raised, and the word is still delivered.
- R9: `rx_valid` is a single-cycle pulse, issued only after the final stop bit has been sampled. `par_err` and `frm_err` can be high only in that cycle. All three outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| line_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Word length code (5 + value bits) |
| cfg_par | input | 3 | Parity mode: 0 none, 1 even, 2 odd, 3 mark, 4 space |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rx_word | output | 8 | Received word, zero-extended |
| rx_valid | output | 1 | One-cycle word strobe |
| par_err | output | 1 | Parity error, valid with rx_valid |
| frm_err | output | 1 | Stop bit sampled low, valid with rx_valid |

## Verification
Every result of a frame is due one clock after the tick that samples the middle of the last stop bit. That tick falls roughly 30 to 40 cycles into the final 64-cycle bit time, counted from when the bench drove the start edge. The bench records the negedge cycle at which `rx_valid` is seen and captures the word and both flags there. It checks that cycle against this window and also confirms that the pulse is gone one cycle later. For a rejected start glitch, the bench waits longer than a whole frame and then checks that no pulse appeared.

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       cfg_stop2,
  output logic [7:0] rx_word,
  output logic       rx_valid,
  output logic       par_err,
  output logic       frm_err
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP1, STOP2} st_t;
  st_t st;

  logic [1:0]    sync;
  logic          prev;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          pbit, bad1;
  logic [7:0]    data_w;
  logic          par_on, par_exp;

  wire rxd = sync[1];
  assign data_w = sh >> (2'd3 - cfg_len);
  assign par_on = (cfg_par >= 3'd1) && (cfg_par <= 3'd4);

  always_comb begin
    case (cfg_par)
      3'd1:    par_exp = ^data_w;
      3'd2:    par_exp = ~^data_w;
      3'd3:    par_exp = 1'b1;
      default: par_exp = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      prev     <= 1'b1;
      st       <= IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      bad1     <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      sync     <= {sync[0], line_in};
      prev     <= rxd;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      case (st)
        IDLE: if (prev && !rxd) begin
          st  <= START;
          cnt <= '0;
        end
        START: if (tick) begin
          if (cnt == HALF) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxd ? IDLE : DATA;
          end else cnt <= cnt + 1'b1;
        end
        default: if (tick) begin
          if (cnt != FULL) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            case (st)
              DATA: begin
                sh  <= {rxd, sh[7:1]};
                idx <= idx + 1'b1;
                if (idx == {1'b0, cfg_len} + 3'd4) st <= par_on ? PAR : STOP1;
              end
              PAR: begin
                pbit <= rxd;
                st   <= STOP1;
              end
              STOP1: begin
                bad1 <= !rxd;
                if (cfg_stop2) st <= STOP2;
                else begin
                  st       <= IDLE;
                  rx_word  <= data_w;
                  rx_valid <= 1'b1;
                  par_err  <= par_on && (pbit != par_exp);
                  frm_err  <= !rxd;
                end
              end
              default: begin
                st       <= IDLE;
                rx_word  <= data_w;
                rx_valid <= 1'b1;
                par_err  <= par_on && (pbit != par_exp);
                frm_err  <= bad1 || !rxd;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ser_rx_props.sv
module ser_rx_props (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_len,
  input logic [2:0] cfg_par,
  input logic [7:0] rx_word,
  input logic       rx_valid,
  input logic       par_err,
  input logic       frm_err
);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_perr_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rx_valid);
  assert_ferr_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> rx_valid);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd0) |-> (rx_word[7:5] == 3'd0));
  assert_no_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (cfg_par == 3'd0 || cfg_par > 3'd4)) |-> !par_err);
endmodule

bind ser_rx ser_rx_props u_props (.*);

// File: tb/ser_rx_test.sv
module ser_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       line_in = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic       cfg_stop2 = 1'b0;
  logic [7:0] rx_word;
  logic       rx_valid, par_err, frm_err;

  int checks = 0, fails = 0, cyc = 0, vcount = 0, vtime = 0;
  logic [7:0] cap_word;
  logic cap_pe, cap_fe;
  logic [1:0] div = '0;
  bit done = 0;

  always #4 clk = ~clk;
  always_ff @(posedge clk) div <= div + 1'b1;
  assign tick = (div == 2'd3);

  ser_rx uut (.clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .rx_word(rx_word), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic prev_v = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin
      vcount++; vtime = cyc;
      cap_word = rx_word; cap_pe = par_err; cap_fe = frm_err;
    end
    if (prev_v) check("R9 pulse width", rx_valid, 0);
    prev_v = rx_valid;
    if (cyc > 150000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic bitout(logic b);
    line_in = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic frame(string req, logic [7:0] d, int len, int pm, bit s2,
                       bit flip, bit sv1, bit sv2, int epe, int efe);
    int n = len + 5, v0 = vcount, t0, nb;
    logic [7:0] m = 8'((1 << n) - 1);
    logic p;
    bit pon = (pm >= 1 && pm <= 4);
    case (pm)
      1: p = ^(d & m);
      2: p = ~^(d & m);
      3: p = 1'b1;
      default: p = 1'b0;
    endcase
    p ^= flip;
    cfg_len = 2'(len); cfg_par = 3'(pm); cfg_stop2 = s2;
    @(negedge clk);
    t0 = cyc;
    bitout(1'b0);
    for (int i = 0; i < n; i++) bitout(d[i]);
    if (pon) bitout(p);
    bitout(sv1);
    if (s2) bitout(sv2);
    line_in = 1'b1;
    repeat (64) @(negedge clk);
    nb = 1 + n + (pon ? 1 : 0) + (s2 ? 2 : 1);
    check({req, " count"}, vcount, v0 + 1);
    check({req, " word"}, cap_word, d & m);
    check({req, " par_err"}, cap_pe, epe);
    check({req, " frm_err"}, cap_fe, efe);
    check({req, " R9 timing"}, int'(vtime - t0 >= (nb-1)*64+28 && vtime - t0 <= (nb-1)*64+44), 1);
  endtask

  task automatic t_reset;
    check("R9 reset valid", rx_valid, 0);
    check("R9 reset word", rx_word, 0);
    check("R9 reset flags", {par_err, frm_err}, 0);
  endtask
  task automatic t_lsb;   frame("R2 a5", 8'hA5, 3, 0, 0, 0, 1, 1, 0, 0);
                          frame("R2 3c", 8'h3C, 3, 0, 0, 0, 1, 1, 0, 0); endtask
  task automatic t_len;   frame("R3 len5", 8'hFF, 0, 0, 0, 0, 1, 1, 0, 0);
                          frame("R3 len6", 8'hEA, 1, 0, 0, 0, 1, 1, 0, 0);
                          frame("R3 len7", 8'hD9, 2, 0, 0, 0, 1, 1, 0, 0); endtask
  task automatic t_even;  frame("R4 good", 8'h4B, 2, 1, 0, 0, 1, 1, 0, 0);
                          frame("R4 bad", 8'h6B, 2, 1, 0, 1, 1, 1, 1, 0); endtask
  task automatic t_odd;   frame("R5 good", 8'h81, 3, 2, 0, 0, 1, 1, 0, 0);
                          frame("R5 bad", 8'h80, 3, 2, 0, 1, 1, 1, 1, 0); endtask
  task automatic t_mksp;  frame("R6 mark bad", 8'h33, 3, 3, 0, 1, 1, 1, 1, 0);
                          frame("R6 mark good", 8'h33, 3, 3, 0, 0, 1, 1, 0, 0);
                          frame("R6 space bad", 8'h0F, 1, 4, 0, 1, 1, 1, 1, 0);
                          frame("R6 space good", 8'h0F, 1, 4, 0, 0, 1, 1, 0, 0); endtask
  task automatic t_none;  frame("R7 none", 8'h96, 3, 0, 0, 0, 1, 1, 0, 0);
                          frame("R7 code6", 8'h5A, 3, 6, 0, 0, 1, 1, 0, 0); endtask
  task automatic t_stop;  frame("R8 stop low", 8'h77, 3, 0, 0, 0, 0, 1, 0, 1);
                          frame("R8 two good", 8'h12, 3, 1, 1, 0, 1, 1, 0, 0);
                          frame("R8 second low", 8'h12, 3, 1, 1, 0, 1, 0, 0, 1); endtask
  task automatic t_glitch;
    int v0 = vcount;
    line_in = 1'b0;
    repeat (12) @(negedge clk);
    line_in = 1'b1;
    repeat (1000) @(negedge clk);
    check("R1 glitch rejected", vcount, v0);
    frame("R1 after glitch", 8'hC3, 3, 0, 0, 0, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    t_lsb; t_len; t_even; t_odd; t_mksp; t_none; t_stop; t_glitch;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule